// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is the software-facing control word for non-volatile memory program and erase cycles. A processor bus writes and reads a single 16-bit word. That word holds four things: an operation code, an enable that arms the array for modification, a start bit, and a sticky error flag. When software sets the start bit with the enable set and a supported code, the block starts a self-timed operation. An internal busy-duration counter stands in for the array. When that counter runs out, the block pulses a completion strobe and hardware clears the start bit. Software can set the start bit but can never clear it.

Starts that are not allowed are refused and recorded in the error flag. This covers a start with the enable clear or a start with an unsupported code. Clearing the enable during an operation also counts as an error: the operation is aborted and the flag is set. The block also handles the processor's power-save requests. A request is refused while an operation runs. If software has selected regulator standby, the array is reported not ready while the processor is idle and for a fixed wake-up delay after it leaves idle. Operation timing is held back until the array is ready again.

Two resets are supported. The power-on reset clears everything. The ordinary system reset leaves the start, enable, error and code fields as they are, and lets an operation in progress run to its end.

Top module: `flash_ctl_reg`

## Requirements
- R1: After power-on reset `bus_rdata` is 0x0000. The read word is laid out as: bit 15 start/busy, bit 14 enable, bit 13 error, bit 12 standby select, bits 3:0 operation code. Bits 11:4 always read 0, whatever was written to them.
- R2: When the block is idle, a write with bit 15 = 1, bit 14 = 1 and a supported code starts an operation. On the next cycle `op_busy_o` is 1 and the read word shows bits 15 and 14 set, bit 13 cleared and the written code.
- R3: The supported codes are 0x0 (configuration byte), 0x1 (word pair), 0x2 (row), 0x3 (page erase), 0xA (auxiliary bulk erase) and 0xD (primary bulk erase). A write with bit 15 = 1 and either bit 14 = 0 or any other code starts nothing. In that case bit 15 reads 0, bit 13 reads 1, and the enable and code fields take the written values.
- R4: With the array ready, an operation of duration D stays busy for D+1 cycles. `op_done_o` is high for exactly one cycle, the last busy cycle, and bit 15 clears on the following edge. D is 4, 6, 10, 12, 16 and 20 cycles for codes 0x0, 0x1, 0x2, 0x3, 0xA and 0xD.
- R5: Software cannot clear bit 15 while busy. A write with bit 15 = 0 and bit 14 = 1 during an operation leaves it busy, and the code field keeps its value.
- R6: A write with bit 14 = 0 during an operation aborts it on the next cycle. Busy falls, bit 13 is set, bit 14 reads 0, and `op_done_o` does not pulse.
- R7: A system reset (`sys_rst_n` low) keeps bits 15, 14, 13 and 3:0, and an operation in progress still completes on time. The same reset clears bit 12 and leaves idle mode.
- R8: A `psave_req` pulse is ignored while an operation is in progress. When no operation is in progress, the pulse puts the block into idle (`idle_o` = 1). A `wake_evt` pulse ends idle.
- R9: In idle with bit 12 = 1, `reg_standby_o` = 1 and `flash_ready_o` = 0. After `wake_evt`, `flash_ready_o` stays 0 for exactly WAKE_CYC = 5 cycles. In idle with bit 12 = 0, `flash_ready_o` stays 1.
- R10: An operation started while the array is not ready does not advance its duration counter until ready returns. Its busy time grows by exactly the number of not-ready cycles.
- R11: When the block is idle, software can clear bit 13 by writing 0 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous system reset, active low |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Current control word |
| psave_req | input | 1 | Power-save (idle) request pulse |
| wake_evt | input | 1 | Idle exit pulse |
| idle_o | output | 1 | Processor idle granted |
| reg_standby_o | output | 1 | Flash regulator in standby |
| flash_ready_o | output | 1 | Array usable |
| op_busy_o | output | 1 | Operation in progress |
| op_code_o | output | 4 | Code of the current operation |
| op_done_o | output | 1 | One-cycle completion strobe |

## Verification
A wrong duration counter shows up on `op_done_o` and on the fall of `op_busy_o`, both off by the same number of cycles. The bench measures this for every code on the first operation. A corrupted start/enable/error field can be seen on the next read of `bus_rdata`, one cycle after the write that caused it. A wrong wake-up counter changes how many cycles `flash_ready_o` stays low after `wake_evt`. Because a deferred operation is held back by that counter, the same fault also lengthens or shortens the busy time of that operation.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef struct packed {
        logic       wr;
        logic       wren;
        logic       err;
        logic       sidl;
        logic [3:0] op;
    } fc_ctl_t;

    localparam logic [3:0] OP_CFG_BYTE = 4'h0;
    localparam logic [3:0] OP_WORD     = 4'h1;
    localparam logic [3:0] OP_ROW      = 4'h2;
    localparam logic [3:0] OP_PAGE     = 4'h3;
    localparam logic [3:0] OP_BULK_AUX = 4'hA;
    localparam logic [3:0] OP_BULK_PRI = 4'hD;

endpackage

// File: rtl/fc_opdecode.sv
module fc_opdecode
    import fc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int T_CFG  = 4,
    parameter int T_WORD = 6,
    parameter int T_ROW  = 10,
    parameter int T_PAGE = 12,
    parameter int T_AUX  = 16,
    parameter int T_PRI  = 20
) (
    input  logic [3:0]       code_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] dur_o
);

    always_comb begin
        valid_o = 1'b1;
        dur_o   = '0;
        unique case (code_i)
            OP_CFG_BYTE: dur_o = CNT_W'(T_CFG);
            OP_WORD:     dur_o = CNT_W'(T_WORD);
            OP_ROW:      dur_o = CNT_W'(T_ROW);
            OP_PAGE:     dur_o = CNT_W'(T_PAGE);
            OP_BULK_AUX: dur_o = CNT_W'(T_AUX);
            OP_BULK_PRI: dur_o = CNT_W'(T_PRI);
            default:     valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fc_optimer.sv
module fc_optimer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             abort_i,
    input  logic             busy_i,
    input  logic             run_ok_i,
    output logic             done_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.done = 1'b0;
        if (abort_i) begin
            tmr_d.cnt = '0;
        end else if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (busy_i && run_ok_i && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
            if (tmr_q.cnt == CNT_W'(1)) begin
                tmr_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done_o = tmr_q.done;

endmodule

// File: rtl/fc_pwr.sv
module fc_pwr #(
    parameter int WAKE_CYC = 5
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst_n,
    input  logic psave_req_i,
    input  logic wake_evt_i,
    input  logic busy_i,
    input  logic sidl_i,
    output logic idle_o,
    output logic standby_o,
    output logic ready_o
);

    localparam int WAKE_W = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic              idle;
        logic [WAKE_W-1:0] wake;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    always_comb begin
        pwr_d = pwr_q;
        if (pwr_q.wake != '0) begin
            pwr_d.wake = pwr_q.wake - 1'b1;
        end
        if (!sys_rst_n) begin
            pwr_d = '0;
        end else if (pwr_q.idle) begin
            if (wake_evt_i) begin
                pwr_d.idle = 1'b0;
                if (sidl_i) begin
                    pwr_d.wake = WAKE_W'(WAKE_CYC);
                end
            end
        end else if (psave_req_i && !busy_i) begin
            pwr_d.idle = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pwr_q <= '0;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign idle_o    = pwr_q.idle;
    assign standby_o = pwr_q.idle && sidl_i;
    assign ready_o   = !standby_o && (pwr_q.wake == '0);

endmodule

// File: rtl/flash_ctl_reg.sv
module flash_ctl_reg
    import fc_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int T_CFG    = 4,
    parameter int T_WORD   = 6,
    parameter int T_ROW    = 10,
    parameter int T_PAGE   = 12,
    parameter int T_AUX    = 16,
    parameter int T_PRI    = 20,
    parameter int WAKE_CYC = 5
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        sys_rst_n,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        psave_req,
    input  logic        wake_evt,
    output logic        idle_o,
    output logic        reg_standby_o,
    output logic        flash_ready_o,
    output logic        op_busy_o,
    output logic [3:0]  op_code_o,
    output logic        op_done_o
);

    localparam int B_WR   = 15;
    localparam int B_WREN = 14;
    localparam int B_ERR  = 13;
    localparam int B_SIDL = 12;

    fc_ctl_t          ctl_d, ctl_q;
    logic             start_d;
    logic             abort_d;
    logic             code_ok;
    logic [CNT_W-1:0] code_dur;
    logic             tmr_done;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[11:4];

    fc_opdecode #(
        .CNT_W(CNT_W), .T_CFG(T_CFG), .T_WORD(T_WORD), .T_ROW(T_ROW),
        .T_PAGE(T_PAGE), .T_AUX(T_AUX), .T_PRI(T_PRI)
    ) u_dec (
        .code_i (bus_wdata[3:0]),
        .valid_o(code_ok),
        .dur_o  (code_dur)
    );

    fc_optimer #(.CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .por_n     (por_n),
        .load_i    (start_d),
        .load_val_i(code_dur),
        .abort_i   (abort_d),
        .busy_i    (ctl_q.wr),
        .run_ok_i  (flash_ready_o),
        .done_o    (tmr_done)
    );

    fc_pwr #(.WAKE_CYC(WAKE_CYC)) u_pwr (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .psave_req_i(psave_req),
        .wake_evt_i (wake_evt),
        .busy_i     (ctl_q.wr),
        .sidl_i     (ctl_q.sidl),
        .idle_o     (idle_o),
        .standby_o  (reg_standby_o),
        .ready_o    (flash_ready_o)
    );

    always_comb begin
        ctl_d   = ctl_q;
        start_d = 1'b0;
        abort_d = 1'b0;
        if (tmr_done) begin
            ctl_d.wr = 1'b0;
        end
        if (!sys_rst_n) begin
            ctl_d.sidl = 1'b0;
        end else if (bus_wr) begin
            if (ctl_q.wr) begin
                if (!tmr_done) begin
                    ctl_d.sidl = bus_wdata[B_SIDL];
                    if (!bus_wdata[B_WREN]) begin
                        ctl_d.wr   = 1'b0;
                        ctl_d.wren = 1'b0;
                        ctl_d.err  = 1'b1;
                        abort_d    = 1'b1;
                    end
                end
            end else begin
                ctl_d.wren = bus_wdata[B_WREN];
                ctl_d.err  = bus_wdata[B_ERR];
                ctl_d.sidl = bus_wdata[B_SIDL];
                ctl_d.op   = bus_wdata[3:0];
                if (bus_wdata[B_WR]) begin
                    if (bus_wdata[B_WREN] && code_ok) begin
                        ctl_d.wr  = 1'b1;
                        ctl_d.err = 1'b0;
                        start_d   = 1'b1;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_rdata = {ctl_q.wr, ctl_q.wren, ctl_q.err, ctl_q.sidl, 8'h00, ctl_q.op};
    assign op_busy_o = ctl_q.wr;
    assign op_code_o = ctl_q.op;
    assign op_done_o = tmr_done;

endmodule

// File: rtl/fc_ctl_chk.sv
module fc_ctl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       bus_wr,
    input logic       wd15,
    input logic       wd14,
    input logic       err_rd,
    input logic       psave_req,
    input logic       idle_o,
    input logic       op_busy_o,
    input logic [3:0] op_code_o,
    input logic       op_done_o
);

    // R4
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        op_done_o |-> op_busy_o);

    // R4
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        op_done_o |=> !op_busy_o);

    // R3
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(op_busy_o) |-> ($past(bus_wr) && $past(wd15) && $past(wd14)));

    // R5
    busy_end_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(op_busy_o) |-> ($past(op_done_o) || ($past(bus_wr) && !$past(wd14))));

    // R6
    abort_flags_err_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(op_busy_o) && !$past(op_done_o)) |-> err_rd);

    // R5
    code_locked_chk: assert property (@(posedge clk) disable iff (!por_n)
        (op_busy_o && $past(op_busy_o)) |-> $stable(op_code_o));

    // R8
    idle_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        (psave_req && op_busy_o) |=> !$rose(idle_o));

endmodule

bind flash_ctl_reg fc_ctl_chk u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .bus_wr   (bus_wr),
    .wd15     (bus_wdata[15]),
    .wd14     (bus_wdata[14]),
    .err_rd   (bus_rdata[13]),
    .psave_req(psave_req),
    .idle_o   (idle_o),
    .op_busy_o(op_busy_o),
    .op_code_o(op_code_o),
    .op_done_o(op_done_o)
);

// File: tb/sim_flash_ctl_reg.sv
`timescale 1ns/1ps
module sim_flash_ctl_reg;

    localparam int WAKE = 5;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        psave_req = 1'b0;
    logic        wake_evt = 1'b0;
    logic        idle_o, reg_standby_o, flash_ready_o, op_busy_o, op_done_o;
    logic [3:0]  op_code_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    flash_ctl_reg #(
        .CNT_W(8), .T_CFG(4), .T_WORD(6), .T_ROW(10), .T_PAGE(12),
        .T_AUX(16), .T_PRI(20), .WAKE_CYC(WAKE)
    ) u0 (.*);

    function automatic int dur_of(input logic [3:0] c);
        case (c)
            4'h0: return 4;
            4'h1: return 6;
            4'h2: return 10;
            4'h3: return 12;
            4'hA: return 16;
            4'hD: return 20;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = v;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic psave();
        @(negedge clk);
        psave_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        psave_req = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk);
        wake_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wake_evt = 1'b0;
    endtask

    // counts busy samples from the current negedge on; reports done samples
    task automatic wait_busy(output int nbusy, output int ndone, output int done_pos);
        nbusy = 0; ndone = 0; done_pos = 0;
        while (op_busy_o && nbusy < 1000) begin
            nbusy++;
            if (op_done_o) begin ndone++; done_pos = nbusy; end
            @(negedge clk);
            wake_evt = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 reset word", bus_rdata, 16'h0000);
        chk("R1 reset busy", op_busy_o, 0);
    endtask

    task automatic t_layout();
        wr(16'h1FF0);
        chk("R1 unused bits read zero", bus_rdata, 16'h1000);
        wr(16'h0000);
    endtask

    task automatic t_reject();
        wr(16'h8001);
        chk("R3 start without enable", bus_rdata, 16'h2001);
        chk("R3 no busy (enable)", op_busy_o, 0);
        wr(16'hC005);
        chk("R3 reserved code 5", bus_rdata, 16'h6005);
        wr(16'hC00F);
        chk("R3 reserved code F", bus_rdata, 16'h600F);
        chk("R3 no busy (code)", op_busy_o, 0);
    endtask

    task automatic t_errclr();
        wr(16'h4000);
        chk("R11 error cleared", bus_rdata, 16'h4000);
    endtask

    task automatic t_durations();
        logic [3:0] codes [6] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'hA, 4'hD};
        for (int i = 0; i < 6; i++) begin
            int nb, nd, dp;
            wr(16'hE000 | 16'(codes[i]));
            chk("R2 start word", bus_rdata, 16'hC000 | 16'(codes[i]));
            chk("R2 busy", op_busy_o, 1);
            wait_busy(nb, nd, dp);
            chk("R4 busy cycles", nb, dur_of(codes[i]) + 1);
            chk("R4 one done pulse", nd, 1);
            chk("R4 done on last busy cycle", dp, nb);
            chk("R4 start bit cleared", bus_rdata, 16'h4000 | 16'(codes[i]));
        end
    endtask

    task automatic t_locked();
        int nb, nd, dp;
        wr(16'hC003);
        wr(16'h4001);
        chk("R5 still busy", op_busy_o, 1);
        chk("R5 code and start kept", bus_rdata, 16'hC003);
        wait_busy(nb, nd, dp);
        chk("R5 completes normally", nd, 1);
    endtask

    task automatic t_abort();
        int nb, nd, dp;
        wr(16'hC002);
        @(negedge clk);
        wr(16'h0002);
        chk("R6 busy dropped", op_busy_o, 0);
        chk("R6 error set, enable clear", bus_rdata, 16'h2002);
        nd = 0;
        for (int i = 0; i < 15; i++) begin
            if (op_done_o) nd++;
            @(negedge clk);
        end
        chk("R6 no done after abort", nd, 0);
        wr(16'h0000);
    endtask

    task automatic t_sysrst();
        int nb, nd, dp;
        wr(16'hD003);
        @(negedge clk);
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
        chk("R7 fields kept, standby bit cleared", bus_rdata, 16'hC003);
        wait_busy(nb, nd, dp);
        chk("R7 op finishes on time", nb, 12 + 1 - 2);
        chk("R7 done seen", nd, 1);
    endtask

    task automatic t_idle();
        int nb, nd, dp;
        wr(16'hC003);
        psave();
        chk("R8 idle refused while busy", idle_o, 0);
        wait_busy(nb, nd, dp);
        psave();
        chk("R8 idle granted", idle_o, 1);
        chk("R9 no standby with select 0", reg_standby_o, 0);
        chk("R9 ready with select 0", flash_ready_o, 1);
        wake();
        chk("R8 idle left", idle_o, 0);
        chk("R9 ready after wake, select 0", flash_ready_o, 1);
    endtask

    task automatic t_wake();
        int nlow;
        wr(16'h1000);
        psave();
        chk("R9 standby", reg_standby_o, 1);
        chk("R9 not ready in standby", flash_ready_o, 0);
        wake();
        nlow = 0;
        while (!flash_ready_o && nlow < 100) begin
            nlow++;
            @(negedge clk);
        end
        chk("R9 wake delay cycles", nlow, WAKE);
        wr(16'h0000);
    endtask

    task automatic t_deferred();
        int nb, nd, dp;
        wr(16'h1000);
        psave();
        wr(16'hD001);
        chk("R10 busy while not ready", op_busy_o, 1);
        wake_evt = 1'b1;
        wait_busy(nb, nd, dp);
        chk("R10 deferred busy cycles", nb, 1 + WAKE + 6 + 1);
        chk("R10 done seen", nd, 1);
        wr(16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_reject();
        t_errclr();
        t_durations();
        t_locked();
        t_abort();
        t_sysrst();
        t_idle();
        t_wake();
        t_deferred();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule